// File: doc/BRIEF.md
# Serial Gigabit Link Autonegotiation Controller

This block sequences link-level autonegotiation for a single serial gigabit port. The port runs in one of three ways: as a 1000BASE-X port, as the PHY side of an SGMII link, or as the MAC side of an SGMII link. For each of these it builds the 16-bit configuration word sent to the partner. It also runs a link timer whose interval is set by the mode, and it resolves link, duplex and speed once negotiation has finished. The serializer and code-group encoding lie outside the block.

Software-style commands reach the block as pulses. A soft reset stays visible while it runs and then clears itself. A restart starts a fresh negotiation, but only if negotiation is enabled and power-down is off. Negotiation moves through four steps. First the partner's word must arrive with its acknowledge bit set. The block then sets its own acknowledge bit and reloads the link timer. When that timer expires, negotiation is complete. A loopback control forces a complete, 1000 Mb/s full-duplex result.

The timer counts prescaler ticks of 2^PRESC_W core clocks. The prescaler is a free-running counter, so the first tick after a load can come at any point within one prescaler period.

Top module: `sgmii_an_ctrl`

## Requirements
- R1: The link timer reloads with (10000·CLK_MHZ)>>PRESC_W ticks in 1000BASE-X mode and (1600·CLK_MHZ)>>PRESC_W ticks in SGMII mode, where one tick is 2^PRESC_W clocks. It is reloaded when a negotiation starts and again when the acknowledged partner word is accepted. timer_expired is a one-cycle pulse. It appears between units·2^PRESC_W and (units+1)·2^PRESC_W+1 cycles after the reload edge.
- R2: In SGMII MAC mode (mode_basex=0, phy_side=0) tx_cfg_word is always 16'h4001, whatever the advertisement inputs are.
- R3: In 1000BASE-X mode tx_cfg_word has full duplex in bit 5, half duplex in bit 6, pause in bits 8:7, remote fault in bits 13:12 and acknowledge in bit 14. All other bits are 0.
- R4: In SGMII PHY mode tx_cfg_word has 1 in bit 0, speed in bits 11:10, duplex in bit 12, acknowledge in bit 14 and link in bit 15. All other bits are 0.
- R5: reset_req sets reset_busy for exactly RESET_CYC cycles, after which it clears itself. The reset abandons any negotiation, so an_complete and the acknowledge bit go to 0. It keeps the enable, power-down and loopback settings, so a later restart works without rewriting them.
- R6: restart_req makes restart_pending read 1 for one cycle, after which it clears itself. A negotiation starts only if an_en=1, pwr_dn=0 and no reset is running. Otherwise the restart has no effect. Setting pwr_dn returns the block to idle.
- R7: Starting a negotiation clears an_complete. A partner word with bit 14 set is accepted only while the block waits for the partner's abilities. an_complete rises one cycle after the following timer expiry.
- R8: In SGMII, the resolution uses the partner word (link bit 15, duplex bit 12, speed bits 11:10) in MAC mode and the local sgm_* advertisement in PHY mode. The speed codes are 0=10, 1=100 and 2=1000 Mb/s. Code 3 forces link down and reports speed 0.
- R9: In 1000BASE-X, full duplex resolves when both sides advertise it. Half duplex is used when only half duplex is common to both. The link is up when either duplex resolves, and the speed is then 2; otherwise link and speed are 0.
- R10: With loopback set, an_complete, link_ok and res_duplex read 1 and res_speed reads 2, in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| mode_basex | input | 1 | 1 = 1000BASE-X, 0 = SGMII |
| phy_side | input | 1 | SGMII role: 1 = PHY side, 0 = MAC side |
| ctl_wr | input | 1 | Loads an_en_in, pwr_dn_in, loop_in |
| an_en_in | input | 1 | Autonegotiation enable value |
| pwr_dn_in | input | 1 | Power-down value |
| loop_in | input | 1 | Loopback value |
| restart_req | input | 1 | Restart negotiation pulse |
| reset_req | input | 1 | Soft reset pulse |
| adv_fd | input | 1 | 1000BASE-X full-duplex advertisement |
| adv_hd | input | 1 | 1000BASE-X half-duplex advertisement |
| adv_pause | input | 2 | 1000BASE-X pause advertisement |
| adv_rfault | input | 2 | 1000BASE-X remote fault |
| sgm_link | input | 1 | SGMII PHY-side link advertisement |
| sgm_dup | input | 1 | SGMII PHY-side duplex advertisement |
| sgm_speed | input | 2 | SGMII PHY-side speed code |
| rx_cfg_valid | input | 1 | Received configuration word strobe |
| rx_cfg_word | input | 16 | Received configuration word |
| tx_cfg_word | output | 16 | Configuration word to transmit |
| timer_expired | output | 1 | Link timer expiry pulse |
| an_complete | output | 1 | Negotiation complete |
| link_ok | output | 1 | Resolved link |
| res_duplex | output | 1 | Resolved duplex (1 = full) |
| res_speed | output | 2 | Resolved speed code |
| reset_busy | output | 1 | Soft reset in progress |
| restart_pending | output | 1 | Restart bit readback |

## Verification
The hardest case to reach from the ports is a restart that arrives during a soft reset. Its effect can only be seen through what does not happen afterwards. The stimulus runs in PHY mode so that the acknowledge bit appears in tx_cfg_word. It issues a restart in the middle of the reset, waits for the reset to end, and then offers an acknowledged partner word. The acknowledge bit must stay 0. A plain restart must then complete a full negotiation, which shows that the enable bit survived the reset. Timer expiry is measured against a window, because the free-running prescaler has an arbitrary phase.

// File: rtl/sgan_pkg.sv
`timescale 1ns/1ps
package sgan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ABILITY,
    ST_LINK_WAIT,
    ST_DONE
  } an_state_e;

  localparam logic [15:0] MAC_SIDE_WORD = 16'h4001;
  localparam int unsigned BASEX_US      = 10000;
  localparam int unsigned SGMII_US      = 1600;
  localparam logic [1:0]  SPD_1000      = 2'd2;
  localparam logic [1:0]  SPD_RSVD      = 2'd3;

  // Link timer reload in prescaler ticks
  function automatic int unsigned link_units(input logic basex,
                                             input int unsigned clk_mhz,
                                             input int unsigned presc_w);
    int unsigned us;
    us = basex ? BASEX_US : SGMII_US;
    return (us * clk_mhz) >> presc_w;
  endfunction

  function automatic logic [15:0] word_basex(input logic ack, input logic [1:0] rf,
                                             input logic [1:0] pause,
                                             input logic hd, input logic fd);
    return {1'b0, ack, rf, 3'b000, pause, hd, fd, 5'b00000};
  endfunction

  function automatic logic [15:0] word_phy(input logic link, input logic ack,
                                           input logic dup, input logic [1:0] spd);
    return {link, ack, 1'b0, dup, spd, 9'd0, 1'b1};
  endfunction

endpackage

// File: rtl/sgan_link_timer.sv
`timescale 1ns/1ps
module sgan_link_timer #(
  parameter int unsigned PRESC_W = 10,
  parameter int unsigned LT_W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            stop,
  input  logic [LT_W-1:0] load_val,
  output logic            expired
);

  logic [PRESC_W-1:0] presc_q;
  logic [LT_W-1:0]    cnt_q;
  logic               run_q;
  logic               exp_q;
  logic               tick;

  assign tick    = &presc_q;
  assign expired = exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (stop) begin
        run_q <= 1'b0;
      end else if (load) begin
        cnt_q <= load_val;
        run_q <= 1'b1;
      end else if (run_q && tick) begin
        if (cnt_q == '0) begin
          exp_q <= 1'b1;
          run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  AST_EXPIRY_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |=> !exp_q); // R1
  AST_LOAD_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !stop) |=> (run_q && !exp_q)); // R1

endmodule

// File: rtl/sgan_seq_ctrl.sv
`timescale 1ns/1ps
module sgan_seq_ctrl
  import sgan_pkg::*;
#(
  parameter int unsigned RESET_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        an_en_in,
  input  logic        pwr_dn_in,
  input  logic        loop_in,
  input  logic        restart_req,
  input  logic        reset_req,
  input  logic        rx_valid,
  input  logic [15:0] rx_word,
  input  logic        timer_expired,
  output logic        an_start,
  output logic        ack_accept,
  output logic        ack_q,
  output logic        done,
  output logic        loop_q,
  output logic        halt,
  output logic [15:0] partner_word,
  output logic        reset_busy,
  output logic        restart_pending
);

  localparam int unsigned RC_W = $clog2(RESET_CYC) + 1;

  an_state_e       state_q;
  logic            an_en_q, pwr_dn_q, rst_an_q, reset_q;
  logic [RC_W-1:0] rcnt_q;

  assign halt            = reset_q | pwr_dn_q;
  assign an_start        = rst_an_q & an_en_q & ~halt;
  assign ack_accept      = (state_q == ST_ABILITY) & rx_valid & rx_word[14] & ~halt & ~an_start;
  assign done            = (state_q == ST_DONE);
  assign reset_busy      = reset_q;
  assign restart_pending = rst_an_q;

  // Control bits and self-clearing commands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      an_en_q  <= 1'b0;
      pwr_dn_q <= 1'b0;
      loop_q   <= 1'b0;
      rst_an_q <= 1'b0;
      reset_q  <= 1'b0;
      rcnt_q   <= '0;
    end else begin
      if (ctl_wr) begin
        an_en_q  <= an_en_in;
        pwr_dn_q <= pwr_dn_in;
        loop_q   <= loop_in;
      end
      rst_an_q <= restart_req;
      if (reset_req) begin
        reset_q <= 1'b1;
        rcnt_q  <= RC_W'(RESET_CYC - 1);
      end else if (reset_q) begin
        if (rcnt_q == '0) reset_q <= 1'b0;
        else              rcnt_q  <= rcnt_q - 1'b1;
      end
    end
  end

  // Negotiation sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      ack_q        <= 1'b0;
      partner_word <= '0;
    end else if (halt) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else if (an_start) begin
      state_q <= ST_ABILITY;
      ack_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_ABILITY: if (ack_accept) begin
          partner_word <= rx_word;
          ack_q        <= 1'b1;
          state_q      <= ST_LINK_WAIT;
        end
        ST_LINK_WAIT: if (timer_expired) state_q <= ST_DONE;
        default: ;
      endcase
    end
  end

  AST_RESET_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    reset_q |=> (state_q == ST_IDLE && !ack_q)); // R5
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    an_start |=> (state_q == ST_ABILITY && !done)); // R7
  AST_DONE_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(timer_expired)); // R7
  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_an_q && !restart_req) |=> !restart_pending); // R6

endmodule

// File: rtl/sgan_resolve.sv
`timescale 1ns/1ps
module sgan_resolve
  import sgan_pkg::*;
(
  input  logic        loop_on,
  input  logic        done,
  input  logic        basex,
  input  logic        phy_side,
  input  logic [15:0] partner,
  input  logic        adv_fd,
  input  logic        adv_hd,
  input  logic        sgm_link,
  input  logic        sgm_dup,
  input  logic [1:0]  sgm_speed,
  output logic        link_ok,
  output logic        duplex,
  output logic [1:0]  speed
);

  logic       fd_common, hd_common, src_link, src_dup;
  logic [1:0] src_spd;
  logic       unused_partner;

  assign unused_partner = ^{partner[14:13], partner[9:7], partner[4:0]};
  assign fd_common = adv_fd & partner[5];
  assign hd_common = adv_hd & partner[6];
  assign src_link  = phy_side ? sgm_link  : partner[15];
  assign src_dup   = phy_side ? sgm_dup   : partner[12];
  assign src_spd   = phy_side ? sgm_speed : partner[11:10];

  always_comb begin
    link_ok = 1'b0;
    duplex  = 1'b0;
    speed   = 2'd0;
    if (loop_on) begin
      link_ok = 1'b1;
      duplex  = 1'b1;
      speed   = SPD_1000;
    end else if (done) begin
      if (basex) begin
        link_ok = fd_common | hd_common;
        duplex  = fd_common;
        speed   = (fd_common | hd_common) ? SPD_1000 : 2'd0;
      end else begin
        duplex = src_dup;
        if (src_spd != SPD_RSVD) begin
          link_ok = src_link;
          speed   = src_spd;
        end
      end
    end
  end

endmodule

// File: rtl/sgmii_an_ctrl.sv
`timescale 1ns/1ps
module sgmii_an_ctrl
  import sgan_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 125,
  parameter int unsigned PRESC_W   = 10,
  parameter int unsigned RESET_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_basex,
  input  logic        phy_side,
  input  logic        ctl_wr,
  input  logic        an_en_in,
  input  logic        pwr_dn_in,
  input  logic        loop_in,
  input  logic        restart_req,
  input  logic        reset_req,
  input  logic        adv_fd,
  input  logic        adv_hd,
  input  logic [1:0]  adv_pause,
  input  logic [1:0]  adv_rfault,
  input  logic        sgm_link,
  input  logic        sgm_dup,
  input  logic [1:0]  sgm_speed,
  input  logic        rx_cfg_valid,
  input  logic [15:0] rx_cfg_word,
  output logic [15:0] tx_cfg_word,
  output logic        timer_expired,
  output logic        an_complete,
  output logic        link_ok,
  output logic        res_duplex,
  output logic [1:0]  res_speed,
  output logic        reset_busy,
  output logic        restart_pending
);

  localparam int unsigned BX_UNITS = link_units(1'b1, CLK_MHZ, PRESC_W);
  localparam int unsigned SG_UNITS = link_units(1'b0, CLK_MHZ, PRESC_W);
  localparam int unsigned LT_W     = $clog2(BX_UNITS + 1) + 1;

  logic            an_start, ack_accept, ack_q, done, loop_q, halt;
  logic [15:0]     partner_word;
  logic [LT_W-1:0] reload;

  assign reload = mode_basex ? LT_W'(BX_UNITS) : LT_W'(SG_UNITS);

  sgan_seq_ctrl #(.RESET_CYC(RESET_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .an_en_in(an_en_in),
    .pwr_dn_in(pwr_dn_in), .loop_in(loop_in), .restart_req(restart_req),
    .reset_req(reset_req), .rx_valid(rx_cfg_valid), .rx_word(rx_cfg_word),
    .timer_expired(timer_expired), .an_start(an_start), .ack_accept(ack_accept),
    .ack_q(ack_q), .done(done), .loop_q(loop_q), .halt(halt),
    .partner_word(partner_word), .reset_busy(reset_busy),
    .restart_pending(restart_pending)
  );

  sgan_link_timer #(.PRESC_W(PRESC_W), .LT_W(LT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(an_start | ack_accept), .stop(halt),
    .load_val(reload), .expired(timer_expired)
  );

  // Transmitted configuration word per operating mode
  always_comb begin
    if (mode_basex)    tx_cfg_word = word_basex(ack_q, adv_rfault, adv_pause, adv_hd, adv_fd);
    else if (phy_side) tx_cfg_word = word_phy(sgm_link, ack_q, sgm_dup, sgm_speed);
    else               tx_cfg_word = MAC_SIDE_WORD;
  end

  sgan_resolve u_res (
    .loop_on(loop_q), .done(done), .basex(mode_basex), .phy_side(phy_side),
    .partner(partner_word), .adv_fd(adv_fd), .adv_hd(adv_hd),
    .sgm_link(sgm_link), .sgm_dup(sgm_dup), .sgm_speed(sgm_speed),
    .link_ok(link_ok), .duplex(res_duplex), .speed(res_speed)
  );

  assign an_complete = loop_q | done;

  AST_MAC_FIXED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_basex && !phy_side) |-> tx_cfg_word == MAC_SIDE_WORD); // R2
  AST_NO_RSVD_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
    res_speed != SPD_RSVD); // R8
  AST_LOOP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_q |-> (an_complete && link_ok && res_duplex && res_speed == SPD_1000)); // R10
  AST_NO_LINK_UNRESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
    (!an_complete) |-> !link_ok); // R7

endmodule

// File: tb/sgmii_an_ctrl_test.sv
`timescale 1ns/1ps
module sgmii_an_ctrl_test;

  localparam int CLK_MHZ = 1;
  localparam int PRESC_W = 10;
  localparam int RCYC    = 8;
  localparam int TICK    = 1 << PRESC_W;
  localparam int BX_U    = (10000 * CLK_MHZ) / TICK;
  localparam int SG_U    = (1600 * CLK_MHZ) / TICK;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_basex = 0, phy_side = 0, ctl_wr = 0, an_en_in = 0, pwr_dn_in = 0, loop_in = 0;
  logic restart_req = 0, reset_req = 0, adv_fd = 0, adv_hd = 0;
  logic [1:0] adv_pause = 0, adv_rfault = 0, sgm_speed = 0;
  logic sgm_link = 0, sgm_dup = 0, rx_cfg_valid = 0;
  logic [15:0] rx_cfg_word = 0;
  logic [15:0] tx_cfg_word;
  logic timer_expired, an_complete, link_ok, res_duplex, reset_busy, restart_pending;
  logic [1:0] res_speed;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sgmii_an_ctrl #(.CLK_MHZ(CLK_MHZ), .PRESC_W(PRESC_W), .RESET_CYC(RCYC)) uut (
    .clk(clk), .rst_n(rst_n), .mode_basex(mode_basex), .phy_side(phy_side),
    .ctl_wr(ctl_wr), .an_en_in(an_en_in), .pwr_dn_in(pwr_dn_in), .loop_in(loop_in),
    .restart_req(restart_req), .reset_req(reset_req), .adv_fd(adv_fd), .adv_hd(adv_hd),
    .adv_pause(adv_pause), .adv_rfault(adv_rfault), .sgm_link(sgm_link),
    .sgm_dup(sgm_dup), .sgm_speed(sgm_speed), .rx_cfg_valid(rx_cfg_valid),
    .rx_cfg_word(rx_cfg_word), .tx_cfg_word(tx_cfg_word), .timer_expired(timer_expired),
    .an_complete(an_complete), .link_ok(link_ok), .res_duplex(res_duplex),
    .res_speed(res_speed), .reset_busy(reset_busy), .restart_pending(restart_pending)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic set_ctl(input logic en, input logic pd, input logic lp);
    @(negedge clk);
    an_en_in = en; pwr_dn_in = pd; loop_in = lp; ctl_wr = 1;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  function automatic logic [15:0] exp_basex(input int ack, input int rf, input int p,
                                            input int hd, input int fd);
    return 16'(ack * 16384 + rf * 4096 + p * 128 + hd * 64 + fd * 32);
  endfunction

  function automatic logic [15:0] exp_phy(input int lk, input int ack, input int dp, input int sp);
    return 16'(lk * 32768 + ack * 16384 + dp * 4096 + sp * 1024 + 1);
  endfunction

  task automatic send_rx(input logic [15:0] w);
    rx_cfg_valid = 1; rx_cfg_word = w;
    @(negedge clk);
    rx_cfg_valid = 0;
  endtask

  // Full negotiation with timer-window measurement
  task automatic negotiate(input logic [15:0] rxw, input int units);
    int n;
    bit seen;
    @(negedge clk) restart_req = 1;
    @(negedge clk) restart_req = 0;
    check("R6 restart bit reads 1", restart_pending, 1);
    @(negedge clk);
    check("R6 restart bit self-clears", restart_pending, 0);
    check("R7 completion cleared by restart", an_complete, 0);
    send_rx(rxw);
    n = 0; seen = 0;
    while (!seen && n < (units + 2) * TICK) begin
      @(negedge clk);
      n++;
      if (timer_expired) seen = 1;
    end
    check("R1 timer expired", seen, 1);
    check("R1 expiry inside window", (n >= units * TICK && n <= (units + 1) * TICK + 1), 1);
    @(negedge clk);
    check("R1 expiry is one pulse", timer_expired, 0);
    check("R7 complete after timer", an_complete, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    check("R7 reset: not complete", an_complete, 0);
    check("R8 reset: link down", link_ok, 0);
    check("R5 reset: not busy", reset_busy, 0);
    check("R6 reset: no restart", restart_pending, 0);
    check("R2 reset: MAC word", tx_cfg_word, 16'h4001);

    // R2: MAC word fixed under advertisement sweep
    for (int i = 0; i < 16; i++) begin
      {adv_pause, adv_fd, adv_hd} = 4'(i); {sgm_speed, sgm_link, sgm_dup} = 4'(15 - i);
      #1 check("R2 MAC fixed word", tx_cfg_word, 16'h4001);
    end

    // R3: 1000BASE-X word sweep
    mode_basex = 1;
    for (int i = 0; i < 64; i++) begin
      {adv_rfault, adv_pause, adv_hd, adv_fd} = 6'(i);
      #1 check("R3 basex word", tx_cfg_word,
               exp_basex(0, i / 16, (i / 4) % 4, (i / 2) % 2, i % 2));
    end

    // R4: PHY word sweep
    mode_basex = 0; phy_side = 1;
    for (int i = 0; i < 16; i++) begin
      {sgm_link, sgm_dup, sgm_speed} = 4'(i);
      #1 check("R4 phy word", tx_cfg_word, exp_phy(i / 8, 0, (i / 4) % 2, i % 4));
    end

    // R8: MAC-side resolution from partner word, all speed codes
    phy_side = 0;
    set_ctl(1, 0, 0);
    for (int s = 0; s < 4; s++) begin
      negotiate(16'(16'h4001 | 16'h8000 | ((s % 2) << 12) | (s << 10)), SG_U);
      check("R8 mac link", link_ok, (s != 3));
      check("R8 mac speed", res_speed, (s == 3) ? 0 : s);
      check("R8 mac duplex", res_duplex, s % 2);
      check("R2 MAC word after ack", tx_cfg_word, 16'h4001);
    end

    // R8/R4: PHY side resolves from own advertisement
    phy_side = 1; sgm_link = 1; sgm_dup = 1; sgm_speed = 1;
    negotiate(16'h4001, SG_U);
    check("R8 phy link", link_ok, 1);
    check("R8 phy speed", res_speed, 1);
    check("R8 phy duplex", res_duplex, 1);
    check("R4 phy word with ack", tx_cfg_word, exp_phy(1, 1, 1, 1));
    sgm_speed = 3;
    #1 check("R8 phy reserved speed link", link_ok, 0);
    check("R8 phy reserved speed value", res_speed, 0);
    sgm_speed = 1;

    // R5/R6: restart during soft reset is dropped; enable survives
    @(negedge clk) reset_req = 1;
    @(negedge clk) reset_req = 0; restart_req = 1;
    check("R5 reset bit set", reset_busy, 1);
    @(negedge clk) restart_req = 0;
    check("R5 reset abandons completion", an_complete, 0);
    check("R5 reset clears ack", tx_cfg_word[14], 0);
    repeat (RCYC - 2) @(negedge clk);
    check("R5 reset still busy at last cycle", reset_busy, 1);
    @(negedge clk);
    check("R5 reset self-clears", reset_busy, 0);
    send_rx(16'h4001);
    check("R6 restart during reset ignored", tx_cfg_word[14], 0);
    check("R6 restart during reset: not complete", an_complete, 0);
    negotiate(16'h4001, SG_U);
    check("R5 enable kept through reset", an_complete, 1);

    // R6: restart with autonegotiation disabled has no effect
    set_ctl(0, 0, 0);
    @(negedge clk) restart_req = 1;
    @(negedge clk) restart_req = 0;
    check("R6 restart bit set while disabled", restart_pending, 1);
    repeat (3) @(negedge clk);
    check("R6 disabled restart keeps complete", an_complete, 1);
    check("R6 disabled restart keeps ack", tx_cfg_word[14], 1);

    // R6: power-down returns to idle
    set_ctl(1, 1, 0);
    @(negedge clk);
    check("R6 power-down clears complete", an_complete, 0);
    check("R6 power-down clears ack", tx_cfg_word[14], 0);
    set_ctl(1, 0, 0);

    // R1/R9: 1000BASE-X negotiation and duplex resolution
    mode_basex = 1; phy_side = 0; adv_fd = 1; adv_hd = 1; adv_pause = 3; adv_rfault = 0;
    negotiate(16'h4060, BX_U);
    check("R9 full duplex link", link_ok, 1);
    check("R9 full duplex", res_duplex, 1);
    check("R9 speed 1000", res_speed, 2);
    check("R3 basex word with ack", tx_cfg_word, exp_basex(1, 0, 3, 1, 1));
    adv_fd = 0;
    #1 check("R9 half duplex link", link_ok, 1);
    check("R9 half duplex", res_duplex, 0);
    adv_hd = 0;
    #1 check("R9 no common duplex link", link_ok, 0);
    check("R9 no common duplex speed", res_speed, 0);

    // R10: loopback forces result even when idle
    set_ctl(1, 1, 1);
    @(negedge clk);
    check("R10 loop complete", an_complete, 1);
    check("R10 loop link", link_ok, 1);
    check("R10 loop duplex", res_duplex, 1);
    check("R10 loop speed", res_speed, 2);
    set_ctl(1, 1, 0);
    @(negedge clk);
    check("R10 loop off releases", an_complete, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule